// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This unit gives each of a parameter number of harts a timer interrupt and a software interrupt. It holds one free-running 64-bit time counter shared by all harts. Each hart has its own 64-bit compare register and its own software-pending bit. The time counter advances by one on every clock cycle in which `tick_en` is high, so the integrator sets the timebase rate by pulsing that input. The timer interrupt of a hart is high whenever the time counter is greater than or equal to that hart's compare value. The software interrupt of a hart follows whatever software last wrote into its bit.

Software reaches the unit over a simple 32-bit register bus with byte addresses. Every 64-bit quantity is seen as two 32-bit words: the low word at the lower address and the high word 4 bytes above it. With the default parameters (4 harts) the software-pending words start at 0x0000 with a stride of 4 bytes. The compare registers start at 0x4000 with a stride of 8 bytes. The time words sit at 0xBFF8 (low) and 0xBFFC (high).

A writer never waits: a write completes in the cycle it is presented. A read is answered one cycle later by a two-state machine:
- IDLE: no response is owed. An accepted read moves the machine to RESP (transition *read-accept*). Any other cycle keeps it in IDLE (*stay-idle*).
- RESP: `bus_rvalid` is high and the captured word is on `bus_rdata`. A further read in the same cycle keeps it in RESP (*read-chain*). Otherwise it returns to IDLE (*retire*).

Top module: `core_timer_unit`

## Requirements
- R1: After reset the time counter and every compare register are 0 and every software-interrupt output is 0. Because 0 >= 0, every timer-interrupt output is 1.
- R2: The time counter increases by exactly 1 at each rising clock edge where `tick_en` is high. It holds its value when `tick_en` is low.
- R3: A read of TIME_BASE returns time bits 31:0, and a read of TIME_BASE+4 returns time bits 63:32. Writes to either address leave the time counter unchanged.
- R4: A write to SOFT_BASE+4*h (h < NUM_HARTS) sets `soft_irq[h]` to 1 when the written word is nonzero and to 0 when it is zero. A read of that address returns 1 in bit 0 when `soft_irq[h]` is set, and 0 in every other bit.
- R5: Compare register h is reached at CMP_BASE+8*h (bits 31:0) and CMP_BASE+8*h+4 (bits 63:32). A write to one half leaves the other half unchanged, and both halves read back as written.
- R6: `timer_irq[h]` is high exactly when time >= compare[h]. It reflects a compare write or a time step from the edge that makes the change, including when both happen at the same edge.
- R7: A read of an address outside the mapped words, or of an address whose two low bits are not 00, returns 0. A write to such an address changes no register and no output.
- R8: An accepted read (`bus_valid` high, `bus_write` low) is answered in the next cycle with `bus_rvalid` high and the data on `bus_rdata`. Back-to-back reads are each answered. `bus_rdata` is 0 whenever `bus_rvalid` is low.
- R9: A write never produces a `bus_rvalid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the time counter this cycle |
| bus_valid | input | 1 | Bus request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the request |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data (0 when not valid) |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt |

## Verification
Two events can land on the same clock edge: the time counter stepping because `tick_en` is high, and a compare-half write from the bus. The bench raises `tick_en` during the very cycle that writes a compare low word equal to time+1, and then during the cycle that writes time+2. After the edge it samples `timer_irq`. It expects 1 in the first case, because the new time equals the new compare. It expects 0 in the second case, and then 1 one tick later. This shows the comparison uses both updated values rather than a stale one.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
    localparam int TIME_W = 64;
    localparam int DATA_W = 32;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_SOFT = 2'd1,
        REG_CMP  = 2'd2,
        REG_TIME = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/ctm_time_counter.sv
module ctm_time_counter
    import ctm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [TIME_W-1:0] time_o
);
    logic [TIME_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_en) begin
            count_q <= count_q + {{(TIME_W-1){1'b0}}, 1'b1};
        end
    end

    assign time_o = count_q;
endmodule

// File: rtl/ctm_hart_bank.sv
module ctm_hart_bank
    import ctm_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [TIME_W-1:0]                time_i,
    input  logic [NUM_HARTS-1:0]             wr_soft,
    input  logic [NUM_HARTS-1:0]             wr_cmp_lo,
    input  logic [NUM_HARTS-1:0]             wr_cmp_hi,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_o,
    output logic [NUM_HARTS-1:0]             soft_o,
    output logic [NUM_HARTS-1:0]             timer_o
);
    localparam int HALF = TIME_W / 2;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic [TIME_W-1:0] cmp_q;
        logic              soft_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q  <= '0;
                soft_q <= 1'b0;
            end else begin
                if (wr_cmp_lo[h]) cmp_q[HALF-1:0]      <= wdata;
                if (wr_cmp_hi[h]) cmp_q[TIME_W-1:HALF] <= wdata;
                if (wr_soft[h])   soft_q               <= |wdata;
            end
        end

        assign cmp_o[h]   = cmp_q;
        assign soft_o[h]  = soft_q;
        assign timer_o[h] = (time_i >= cmp_q);
    end
endmodule

// File: rtl/ctm_bus_port.sv
module ctm_bus_port
    import ctm_pkg::*;
#(
    parameter int          NUM_HARTS = 4,
    parameter int          ADDR_W    = 16,
    parameter int unsigned SOFT_BASE = 32'h0000,
    parameter int unsigned CMP_BASE  = 32'h4000,
    parameter int unsigned TIME_BASE = 32'hBFF8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_valid,
    input  logic                             bus_write,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_i,
    input  logic [NUM_HARTS-1:0]             soft_i,
    input  logic [TIME_W-1:0]                time_i,
    output logic [NUM_HARTS-1:0]             wr_soft,
    output logic [NUM_HARTS-1:0]             wr_cmp_lo,
    output logic [NUM_HARTS-1:0]             wr_cmp_hi,
    output logic                             bus_rvalid,
    output logic [DATA_W-1:0]                bus_rdata
);
    localparam int HIDX_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
    localparam int SOFT_SPAN = 4 * NUM_HARTS;
    localparam int CMP_SPAN  = 8 * NUM_HARTS;
    localparam int HALF      = TIME_W / 2;

    localparam logic [ADDR_W-1:0] SOFT_A  = SOFT_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] CMP_A   = CMP_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] TIME_LO = TIME_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] TIME_HI = TIME_LO + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] SOFT_SP = SOFT_SPAN[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] CMP_SP  = CMP_SPAN[ADDR_W-1:0];

    // address decode
    logic [ADDR_W-1:0] soft_off, cmp_off;
    logic              aligned;
    reg_kind_e         kind;
    logic [HIDX_W-1:0] hart;
    logic              upper;

    always_comb begin
        soft_off = bus_addr - SOFT_A;
        cmp_off  = bus_addr - CMP_A;
        aligned  = (bus_addr[1:0] == 2'b00);
        kind     = REG_NONE;
        hart     = '0;
        upper    = 1'b0;
        if (aligned) begin
            if (soft_off < SOFT_SP) begin
                kind = REG_SOFT;
                hart = soft_off[2 +: HIDX_W];
            end else if (cmp_off < CMP_SP) begin
                kind  = REG_CMP;
                hart  = cmp_off[3 +: HIDX_W];
                upper = cmp_off[2];
            end else if (bus_addr == TIME_LO) begin
                kind = REG_TIME;
            end else if (bus_addr == TIME_HI) begin
                kind  = REG_TIME;
                upper = 1'b1;
            end
        end
    end

    // write strobes
    logic do_write, do_read;
    assign do_write = bus_valid && bus_write;
    assign do_read  = bus_valid && !bus_write;

    always_comb begin
        wr_soft   = '0;
        wr_cmp_lo = '0;
        wr_cmp_hi = '0;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (do_write && (int'(hart) == h)) begin
                wr_soft[h]   = (kind == REG_SOFT);
                wr_cmp_lo[h] = (kind == REG_CMP) && !upper;
                wr_cmp_hi[h] = (kind == REG_CMP) && upper;
            end
        end
    end

    // read mux
    logic [DATA_W-1:0] rd_next;
    logic [TIME_W-1:0] cmp_sel;

    always_comb begin
        cmp_sel = '0;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (int'(hart) == h) cmp_sel = cmp_i[h];
        end
        unique case (kind)
            REG_SOFT: rd_next = {{(DATA_W-1){1'b0}}, soft_i[hart]};
            REG_CMP:  rd_next = upper ? cmp_sel[TIME_W-1:HALF] : cmp_sel[HALF-1:0];
            REG_TIME: rd_next = upper ? time_i[TIME_W-1:HALF] : time_i[HALF-1:0];
            default:  rd_next = '0;
        endcase
    end

    // response state machine
    bus_state_e        state_q, state_d;
    logic [DATA_W-1:0] rd_q;

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = do_read ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = do_read ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (do_read) rd_q <= rd_next;
        end
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
        bus_rdata  = bus_rvalid ? rd_q : '0;
    end
endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit
    import ctm_pkg::*;
#(
    parameter int          NUM_HARTS = 4,
    parameter int          ADDR_W    = 16,
    parameter int unsigned SOFT_BASE = 32'h0000,
    parameter int unsigned CMP_BASE  = 32'h4000,
    parameter int unsigned TIME_BASE = 32'hBFF8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic                 bus_rvalid,
    output logic [31:0]          bus_rdata,
    output logic [NUM_HARTS-1:0] timer_irq,
    output logic [NUM_HARTS-1:0] soft_irq
);
    logic [TIME_W-1:0]                time_val;
    logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_val;
    logic [NUM_HARTS-1:0]             wr_soft, wr_cmp_lo, wr_cmp_hi;

    ctm_time_counter u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .time_o  (time_val)
    );

    ctm_hart_bank #(.NUM_HARTS(NUM_HARTS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .time_i    (time_val),
        .wr_soft   (wr_soft),
        .wr_cmp_lo (wr_cmp_lo),
        .wr_cmp_hi (wr_cmp_hi),
        .wdata     (bus_wdata),
        .cmp_o     (cmp_val),
        .soft_o    (soft_irq),
        .timer_o   (timer_irq)
    );

    ctm_bus_port #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W),
        .SOFT_BASE (SOFT_BASE),
        .CMP_BASE  (CMP_BASE),
        .TIME_BASE (TIME_BASE)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .cmp_i      (cmp_val),
        .soft_i     (soft_irq),
        .time_i     (time_val),
        .wr_soft    (wr_soft),
        .wr_cmp_lo  (wr_cmp_lo),
        .wr_cmp_hi  (wr_cmp_hi),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata)
    );
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
    parameter int NUM_HARTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic                 bus_rvalid,
    input logic [31:0]          bus_rdata,
    input logic [NUM_HARTS-1:0] timer_irq,
    input logic [NUM_HARTS-1:0] soft_irq,
    input logic [63:0]          time_val
);
    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (time_val == $past(time_val) + 64'd1)); // R2
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(time_val)); // R2
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid); // R8
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == 32'd0)); // R8
    AST_WRITE_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> !bus_rvalid); // R9
    AST_SOFT_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> $stable(soft_irq)); // R4

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_irq
        AST_TIMER_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
            (timer_irq[h] && !(bus_valid && bus_write)) |=> timer_irq[h]); // R6
    end
endmodule

bind core_timer_unit ctm_checker #(.NUM_HARTS(NUM_HARTS)) u_ctm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .timer_irq  (timer_irq),
    .soft_irq   (soft_irq),
    .time_val   (time_val)
);

// File: tb/test_core_timer_unit.sv
module test_core_timer_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 16;
    localparam logic [AW-1:0] SB = 16'h0000;
    localparam logic [AW-1:0] CB = 16'h4000;
    localparam logic [AW-1:0] TB = 16'hBFF8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  timer_irq, soft_irq;

    int vectors = 0;
    int errors  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    core_timer_unit i_core_timer_unit (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .timer_irq(timer_irq), .soft_irq(soft_irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: entered and left at a falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // monitor: compares responses against the queue
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                vectors++; errors++;
                $display("FAIL R9: actual unexpected response %h expected none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(32'(soft_irq), 32'h0, "R1 soft after reset");
        check(32'(timer_irq), 32'hF, "R1 timer after reset");
        rd(CB, 32'h0, "R1 cmp0 lo reset");
        rd(TB, 32'h0, "R1 time lo reset");

        // software interrupt bits
        wr(SB + 16'd8, 32'h100);
        check(32'(soft_irq), 32'h4, "R4 nonzero sets bit");
        rd(SB + 16'd8, 32'h1, "R4 read set bit");
        wr(SB + 16'd8, 32'h0);
        wr(SB + 16'd4, 32'h1);
        check(32'(soft_irq), 32'h2, "R4 zero clears, one sets");
        rd(SB + 16'd4, 32'h1, "R4 read hart1");
        rd(SB, 32'h0, "R4 read hart0");

        // unmapped and misaligned
        rd(SB + 16'd1, 32'h0, "R7 misaligned read");
        wr(SB + 16'd5, 32'hFFFF_FFFF);
        rd(16'h2000, 32'h0, "R7 unmapped read");
        wr(16'h2000, 32'hFFFF_FFFF);
        wr(SB + 16'd16, 32'h1);
        wr(CB + 16'd33, 32'h1);
        check(32'(soft_irq), 32'h2, "R7 soft unchanged");
        check(32'(timer_irq), 32'hF, "R7 timer unchanged");
        rd(SB + 16'd16, 32'h0, "R7 beyond last hart");

        // compare halves (time is 0)
        wr(CB + 16'd28, 32'h1);
        check(32'(timer_irq), 32'h7, "R6 high half raises compare");
        wr(CB + 16'd24, 32'h55);
        rd(CB + 16'd28, 32'h1, "R5 high kept");
        rd(CB + 16'd24, 32'h55, "R5 low written");
        wr(CB + 16'd28, 32'h0);
        rd(CB + 16'd24, 32'h55, "R5 low kept");
        check(32'(timer_irq), 32'h7, "R6 cmp 0x55 above time");
        wr(CB + 16'd24, 32'h0);
        check(32'(timer_irq), 32'hF, "R6 cmp back to 0");

        // time words
        wr(TB, 32'h1234);
        wr(TB + 16'd4, 32'h1);
        rd(TB, 32'h0, "R3 time lo write ignored");
        rd(TB + 16'd4, 32'h0, "R3 time hi write ignored");

        // counting
        ticks(5);
        rd(TB, 32'd5, "R2 five ticks");
        rd(TB, 32'd5, "R2 hold without tick");

        // compare vs time, time is 5
        wr(CB, 32'd7);
        check(32'(timer_irq), 32'hE, "R6 future compare clears");
        ticks(1);
        check(32'(timer_irq), 32'hE, "R6 time 6 below 7");
        ticks(1);
        check(32'(timer_irq), 32'hF, "R6 time reaches 7");

        // tick and compare write on the same edge (time 7)
        tick_en = 1'b1;
        wr(CB + 16'd8, 32'd8);
        tick_en = 1'b0;
        check(32'(timer_irq), 32'hF, "R6 same-edge equal");
        tick_en = 1'b1;
        wr(CB + 16'd16, 32'd10);
        tick_en = 1'b0;
        check(32'(timer_irq), 32'hB, "R6 same-edge future");
        ticks(1);
        check(32'(timer_irq), 32'hF, "R6 reaches 10");
        rd(TB, 32'd10, "R3 time lo after ticks");

        @(negedge clk);
        @(negedge clk);
        check(32'(exp_q.size()), 32'h0, "R8 all reads answered");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule